// File: doc/BRIEF.md
# Thermostat Alert with Fault Queue

This block watches a stream of completed temperature conversions and decides when a thermostat alert line should be raised or dropped. Each conversion result arrives with a one-cycle strobe. The block compares the result against a programmable upper trip point and a programmable lower release point. It raises or drops the alert only after a programmable number of consecutive conversions meet the condition it is waiting for. This debounce keeps a noisy reading near a limit from making the alert chatter.

The block has two behaviours. In comparator mode the alert follows the temperature with hysteresis: it goes active at or above the upper limit and goes inactive again below the lower limit. In interrupt mode the alert latches when its condition is met and stays latched until the host acknowledges it. The host acknowledges by reading any register, by winning an alert-response cycle, or by entering shutdown. After each acknowledge, the interrupt-mode watch switches between the upper and the lower limit.

A status bit records which limit caused the latest alert. The pin polarity is selectable. Register storage and the serial bus sit outside the block. The block receives the limits, the mode fields and the host events as plain inputs.

Top module: `thermostat_alert`

## Requirements
- R1: The fault-queue code `fq` selects how many consecutive qualifying conversions change the alert: 0 needs 1, 1 needs 2, 2 needs 4, and 3 needs 6.
- R2: In comparator mode (`intr_mode`=0) with the alert inactive, a conversion whose result is greater than or equal to `lim_hi` counts as a fault. The alert becomes active in the cycle after the strobe of the last required fault.
- R3: In comparator mode with the alert active, only results below `lim_lo` count. The alert becomes inactive after the same number of consecutive such results.
- R4: In interrupt mode (`intr_mode`=1), an active alert stays active, and further conversions are ignored, until a pulse on `reg_read`, `resp_won` or `sd_enter`. That pulse makes the alert inactive in the next cycle.
- R5: In interrupt mode, the watch starts on the upper condition (result >= `lim_hi`). After each latched alert, the next alert is caused only by results below `lim_lo`, and the watch keeps switching back and forth this way.
- R6: With `pol`=0 the pin is low when the alert is active and high when it is inactive. With `pol`=1 the pin is high when the alert is active.
- R7: All comparisons are signed two's-complement over all 12 bits of the result and of both limits. Bit 11 is the sign bit, and a limit's low bit affects the outcome.
- R8: `alert_cause` is set to 1 when an alert is raised by the upper condition and to 0 when an interrupt-mode alert is raised by the lower condition. It keeps its value otherwise.
- R9: A conversion that does not meet the awaited condition returns the consecutive-fault count to zero.
- R10: Any change of `intr_mode` or `fq` returns the fault count to zero.
- R11: A `soft_reset` pulse makes the alert inactive, clears the count and `alert_cause`, and returns the interrupt-mode watch to the upper condition.
- R12: If an interrupt-mode acknowledge and a conversion strobe fall in the same cycle while the alert is active, the alert is cleared and that conversion does not count toward the next alert.
- R13: After `rst_n` is released, the alert is inactive and `alert_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe: a new conversion result is ready |
| res_temp | input | 12 | Conversion result, signed, 1/16 degree per LSB |
| lim_hi | input | 12 | Upper trip point, signed |
| lim_lo | input | 12 | Lower release point, signed |
| intr_mode | input | 1 | 0 comparator mode, 1 interrupt mode |
| pol | input | 1 | Pin polarity: 1 active-high, 0 active-low |
| fq | input | 2 | Fault-queue code |
| reg_read | input | 1 | Pulse: host read some register |
| resp_won | input | 1 | Pulse: this block won an alert-response cycle |
| sd_enter | input | 1 | Pulse: entry into shutdown |
| soft_reset | input | 1 | Pulse: reset command from the bus |
| alert_pin | output | 1 | Alert pin level after polarity |
| alert_cause | output | 1 | 1 upper-limit cause, 0 lower-limit cause |

## Verification
Two of this block's functions can fall in the same cycle in interrupt mode: acknowledging a latched alert and counting a new conversion. The bench provokes this by pulsing `reg_read` in the very cycle of a result strobe that would qualify for the next watch phase, with a two-conversion fault queue. The pin must go inactive. Then one further qualifying conversion must leave it inactive and a second must raise it. That outcome shows the simultaneous conversion was discarded rather than counted.

// File: rtl/thermostat_alert.sv
module thermostat_alert #(
  parameter int TW = 12,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [TW-1:0] res_temp,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  input  logic          intr_mode,
  input  logic          pol,
  input  logic [1:0]    fq,
  input  logic          reg_read,
  input  logic          resp_won,
  input  logic          sd_enter,
  input  logic          soft_reset,
  output logic          alert_pin,
  output logic          alert_cause
);

  logic          active, phase, mode_q;
  logic [1:0]    fq_q;
  logic [CW-1:0] cnt, need, base, incr;
  logic          ge_hi, lt_lo, awaited, clr_evt, cfg_chg, count_en, hit;

  always_comb begin
    case (fq)
      2'd0:    need = CW'(1);
      2'd1:    need = CW'(2);
      2'd2:    need = CW'(4);
      default: need = CW'(6);
    endcase
  end

  assign ge_hi    = $signed(res_temp) >= $signed(lim_hi);
  assign lt_lo    = $signed(res_temp) <  $signed(lim_lo);
  assign awaited  = (intr_mode ? phase : active) ? lt_lo : ge_hi;
  assign clr_evt  = intr_mode && active && (reg_read || resp_won || sd_enter);
  assign cfg_chg  = (intr_mode != mode_q) || (fq != fq_q);
  assign base     = cfg_chg ? '0 : cnt;
  assign incr     = base + CW'(1);
  assign count_en = res_valid && !(intr_mode && active);
  assign hit      = count_en && awaited && (incr == need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      phase       <= 1'b0;
      alert_cause <= 1'b0;
      cnt         <= '0;
      mode_q      <= 1'b0;
      fq_q        <= 2'd0;
    end else begin
      mode_q <= intr_mode;
      fq_q   <= fq;
      if (soft_reset) begin
        active      <= 1'b0;
        phase       <= 1'b0;
        alert_cause <= 1'b0;
        cnt         <= '0;
      end else if (clr_evt) begin
        active <= 1'b0;
        cnt    <= base;
      end else if (hit) begin
        cnt <= '0;
        if (intr_mode) begin
          active      <= 1'b1;
          alert_cause <= ~phase;
          phase       <= ~phase;
        end else begin
          active <= ~active;
          if (!active) alert_cause <= 1'b1;
        end
      end else if (count_en) begin
        cnt <= awaited ? incr : '0;
      end else begin
        cnt <= base;
      end
    end
  end

  assign alert_pin = pol ? active : ~active;

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(5));

  a_r2_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(res_valid));

  a_r3_comp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_mode && !res_valid && !soft_reset |=> $stable(active));

  a_r4_intr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    intr_mode && active && (reg_read || resp_won || sd_enter) |=> !active);

  a_r8_comp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) && $past(!intr_mode) |-> alert_cause);

  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !active && cnt == '0 && !alert_cause);

endmodule

// File: tb/sim_thermostat_alert.sv
module sim_thermostat_alert;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic res_valid = 0, intr_mode = 0, pol = 0;
  logic reg_read = 0, resp_won = 0, sd_enter = 0, soft_reset = 0;
  logic [11:0] res_temp = '0, lim_hi = 12'h500, lim_lo = 12'h4B0;
  logic [1:0] fq = 2'd0;
  logic alert_pin, alert_cause;
  int checks = 0, failures = 0, cycles = 0;

  thermostat_alert u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_temp(res_temp),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .intr_mode(intr_mode), .pol(pol), .fq(fq),
    .reg_read(reg_read), .resp_won(resp_won), .sd_enter(sd_enter),
    .soft_reset(soft_reset), .alert_pin(alert_pin), .alert_cause(alert_cause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bit 12: expected alert active, bits 11:0: result; comparator, fq=1, pol=0
  localparam logic [12:0] VEC [0:11] = '{
    13'h0400, 13'h0500, 13'h03F0, 13'h0500, 13'h1600, 13'h14B0,
    13'h14AF, 13'h14C0, 13'h14A0, 13'h0E70, 13'h07FF, 13'h0800
  };

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [11:0] t,
                      input logic rd, input logic rw, input logic sd, input logic sr);
    @(negedge clk);
    res_valid = v; res_temp = t; reg_read = rd; resp_won = rw;
    sd_enter = sd; soft_reset = sr;
    @(negedge clk);
    res_valid = 0; reg_read = 0; resp_won = 0; sd_enter = 0; soft_reset = 0;
  endtask

  task automatic conv(input logic [11:0] t);
    step(1'b1, t, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic act_is(input logic exp, input string req);
    chk(alert_pin, pol ? exp : ~exp, req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    act_is(1'b0, "R13 reset pin");
    chk(alert_cause, 1'b0, "R13 reset cause");

    // table walk: R2 R3 R7 R9
    fq = 2'd1;
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++) begin
      conv(VEC[i][11:0]);
      act_is(VEC[i][12], $sformatf("R2/R3/R7/R9 vector %0d", i));
    end

    // R1: six faults for code 3
    fq = 2'd3;
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) conv(12'h500);
    act_is(1'b0, "R1 code3 five faults");
    conv(12'h500);
    act_is(1'b1, "R1 code3 sixth fault");
    chk(alert_cause, 1'b1, "R8 upper cause");
    fq = 2'd0;
    step(0, 0, 0, 0, 0, 0);
    conv(12'h100);
    act_is(1'b0, "R1 code0 single release");
    fq = 2'd2;
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) conv(12'h600);
    act_is(1'b0, "R1 code2 three faults");
    conv(12'h600);
    act_is(1'b1, "R1 code2 fourth fault");
    step(0, 0, 0, 0, 0, 1);
    act_is(1'b0, "R11 soft reset comparator");
    chk(alert_cause, 1'b0, "R11 cause cleared");

    // R7: low bit of limit matters
    fq = 2'd0; lim_hi = 12'h501;
    step(0, 0, 0, 0, 0, 0);
    conv(12'h500);
    act_is(1'b0, "R7 below by one lsb");
    conv(12'h501);
    act_is(1'b1, "R7 equal to limit");
    lim_hi = 12'h500;
    step(0, 0, 0, 0, 0, 1);

    // R6 polarity
    pol = 1'b1; #1;
    chk(alert_pin, 1'b0, "R6 pol1 inactive");
    conv(12'h600);
    chk(alert_pin, 1'b1, "R6 pol1 active");
    pol = 1'b0; #1;
    chk(alert_pin, 1'b0, "R6 pol0 active low");
    step(0, 0, 0, 0, 0, 1);

    // R10 config change clears count
    fq = 2'd1;
    step(0, 0, 0, 0, 0, 0);
    conv(12'h600);
    fq = 2'd2;
    step(0, 0, 0, 0, 0, 0);
    fq = 2'd1;
    step(0, 0, 0, 0, 0, 0);
    conv(12'h600);
    act_is(1'b0, "R10 count cleared by fq change");
    conv(12'h600);
    act_is(1'b1, "R10 count restarted");
    step(0, 0, 0, 0, 0, 1);

    // interrupt mode R4 R5 R8
    intr_mode = 1'b1; fq = 2'd0;
    step(0, 0, 0, 0, 0, 0);
    conv(12'h100);
    act_is(1'b0, "R5 starts on upper watch");
    conv(12'h600);
    act_is(1'b1, "R4 interrupt raise");
    chk(alert_cause, 1'b1, "R8 interrupt upper cause");
    conv(12'h100);
    act_is(1'b1, "R4 latched despite low result");
    step(0, 0, 1, 0, 0, 0);
    act_is(1'b0, "R4 cleared by read");
    conv(12'h600);
    act_is(1'b0, "R5 now watching lower");
    conv(12'h100);
    act_is(1'b1, "R5 lower raise");
    chk(alert_cause, 1'b0, "R8 lower cause");
    step(0, 0, 0, 1, 0, 0);
    act_is(1'b0, "R4 cleared by response");
    conv(12'h100);
    act_is(1'b0, "R5 back to upper watch");
    conv(12'h600);
    act_is(1'b1, "R5 upper raise again");
    step(0, 0, 0, 0, 1, 0);
    act_is(1'b0, "R4 cleared by shutdown");

    // R12 simultaneous clear and conversion (watching lower now)
    fq = 2'd1;
    step(0, 0, 0, 0, 0, 0);
    conv(12'h100);
    conv(12'h100);
    act_is(1'b1, "R12 setup lower raise");
    step(1, 12'h600, 1, 0, 0, 0);
    act_is(1'b0, "R12 clear wins");
    conv(12'h600);
    act_is(1'b0, "R12 simultaneous conversion discarded");
    conv(12'h600);
    act_is(1'b1, "R12 second fault raises");

    // R11 in interrupt mode: watch returns to upper
    step(0, 0, 0, 0, 0, 1);
    act_is(1'b0, "R11 soft reset interrupt");
    conv(12'h100);
    conv(12'h100);
    act_is(1'b0, "R11 lower ignored after reset");
    conv(12'h600);
    conv(12'h600);
    act_is(1'b1, "R11 upper watch restored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule